// File: doc/BRIEF.md
# Memory March Test Engine

This block drives a single-port SRAM during built-in self test. Once started, it issues one memory command per cycle. Each command carries an address, a write enable and write data. The commands follow one of three march algorithms, and the block compares the data returned by every read against the word it expects. The write and compare words both come from a programmable 4-bit seed. That seed is either repeated across the word or repeated and then inverted.

The address walk can move the row field fastest or the column field fastest. Each element of an algorithm visits every address once, either ascending or descending. At each address it finishes all of that element's operations before it moves on. When the run ends, the block raises a done flag and holds the result. The result is pass or fail, plus the address of the first read that mismatched. It keeps these until the next start.

Top module: `march_engine`

## Requirements
- R1: A start pulse sampled while the engine is idle or finished latches the algorithm, ordering and seed, and the first command appears in the next cycle. A start pulse while busy is ignored, and the running sequence continues unchanged.
- R2: Algorithm code 0 (and the spare code 3) runs six elements: write-0 ascending; (read-0, write-1, read-1) ascending; (read-1, write-0, read-0) ascending; (read-0, write-1, read-1) descending; (read-1, write-0, read-0) descending; read-0 ascending.
- R3: Algorithm code 1 runs four elements: write-0 ascending; (read-0, write-1) ascending; (read-1, write-0) descending; read-0 ascending.
- R4: Algorithm code 2 runs four elements: write-0 ascending; (read-0, write-1, read-1) ascending; (read-1, write-0, read-0) descending; read-0 ascending.
- R5: Ascending elements walk the index i from 0 to 127, and descending elements walk it from 127 to 0. All operations of the element complete at one address before the index moves.
- R6: mem_addr[6:3] is the row and mem_addr[2:0] is the column. With y_fast = 0, row = i mod 16 and column = i div 16.
- R7: With y_fast = 1, column = i mod 8 and row = i div 8, so mem_addr equals i.
- R8: The "0" word is the seed repeated four times (bit k = seed[k mod 4]), and the "1" word is its bitwise inverse. A write drives the word on mem_wdata, and a read expects it on mem_rdata one cycle after the read command.
- R9: Any read mismatch makes the run fail. fail_addr holds the address of the first mismatching read in command order, and later mismatches do not change it.
- R10: After the last command comes one drain cycle with busy high and no command. Then done rises, busy falls, and pass shows whether no read mismatched. done, pass and fail_addr hold until the next start.
- R11: After reset, busy, done, pass and mem_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| algo | input | 2 | Algorithm select: 0/3 six-element, 1 read-write, 2 read-write-read |
| y_fast | input | 1 | 1: column moves fastest, 0: row moves fastest |
| seed | input | 4 | Data seed |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | Command is a write |
| mem_addr | output | 7 | Memory address {row, column} |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the read command |
| busy | output | 1 | Run in progress, including the drain cycle |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Finished with no mismatch |
| fail_addr | output | 7 | Address of the first mismatching read |

## Verification
The first command is due in the cycle after start is sampled, and one more follows in each later cycle. The bench therefore compares every command against a trace it builds from the element lists, with one comparison per falling edge. The drain cycle is due one cycle after the last command, and done, pass and fail_addr are due in the cycle after that. Each run checks these at those exact edges and then checks again a few cycles later to confirm the results hold. Mismatches are produced by stuck-at bits in the bench RAM, placed so that the x-fast and y-fast walks reach a different faulty address first.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam logic [1:0] ALG_CP  = 2'd0;
  localparam logic [1:0] ALG_RW  = 2'd1;
  localparam logic [1:0] ALG_RWR = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} st_e;
  typedef enum logic [1:0] {K_FILL, K_RISE, K_FALL, K_VERIFY} kind_e;

  typedef struct packed {
    logic wr;
    logic inv;
  } op_t;

  function automatic logic [2:0] final_elem(input logic [1:0] alg);
    return (alg == ALG_RW || alg == ALG_RWR) ? 3'd3 : 3'd5;
  endfunction

  function automatic kind_e elem_kind(input logic [1:0] alg, input logic [2:0] elem);
    if (elem == 3'd0)                 return K_FILL;
    else if (elem == final_elem(alg)) return K_VERIFY;
    else if (elem[0])                 return K_RISE;
    else                              return K_FALL;
  endfunction

  function automatic logic [1:0] final_step(input logic [1:0] alg, input logic [2:0] elem);
    kind_e k;
    k = elem_kind(alg, elem);
    if (k == K_FILL || k == K_VERIFY) return 2'd0;
    else if (alg == ALG_RW)           return 2'd1;
    else                              return 2'd2;
  endfunction

  function automatic logic elem_desc(input logic [1:0] alg, input logic [2:0] elem);
    kind_e k;
    k = elem_kind(alg, elem);
    if (k == K_FILL || k == K_VERIFY)      return 1'b0;
    else if (alg == ALG_RW || alg == ALG_RWR) return (k == K_FALL);
    else                                    return (elem > 3'd2);
  endfunction

  function automatic op_t op_at(input logic [1:0] alg, input logic [2:0] elem,
                                input logic [1:0] step);
    op_t o;
    o.wr  = 1'b0;
    o.inv = 1'b0;
    case (elem_kind(alg, elem))
      K_FILL:  o.wr = 1'b1;
      K_RISE:  begin o.wr = (step == 2'd1); o.inv = (step != 2'd0); end
      K_FALL:  begin o.wr = (step == 2'd1); o.inv = (step == 2'd0); end
      default: o.wr = 1'b0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int AW = ROW_W + COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_desc,
  input  logic          adv,
  input  logic          desc,
  input  logic          y_fast,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  logic [AW-1:0] idx;

  // walk index -> {row, col}
  function automatic logic [AW-1:0] map_addr(input logic [AW-1:0] i, input logic yf);
    if (yf) return i;
    return {i[ROW_W-1:0], i[AW-1:ROW_W]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (load) idx <= load_desc ? '1 : '0;
    else if (adv)  idx <= desc ? idx - 1'b1 : idx + 1'b1;
  end

  assign addr   = map_addr(idx, y_fast);
  assign at_end = desc ? (idx == '0) : (idx == '1);

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_issue,
  input  logic [DW-1:0] exp_word,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rdata,
  output logic          mismatch,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);

  logic          rd_pend;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      exp_q   <= '0;
      addr_q  <= '0;
    end else begin
      rd_pend <= rd_issue;
      exp_q   <= exp_word;
      addr_q  <= rd_addr;
    end
  end

  assign mismatch = rd_pend && (rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_q;
    end
  end

endmodule

// File: rtl/march_engine.sv
module march_engine
  import march_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  localparam int AW    = ROW_W + COL_W,
  localparam int SEED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        algo,
  input  logic              y_fast,
  input  logic [SEED_W-1:0] seed,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [AW-1:0]     fail_addr
);

  function automatic logic [DATA_W-1:0] seed_word(input logic [SEED_W-1:0] s, input logic inv);
    logic [DATA_W-1:0] w;
    for (int b = 0; b < DATA_W; b++) w[b] = s[b % SEED_W] ^ inv;
    return w;
  endfunction

  st_e               st;
  logic [1:0]        cfg_alg;
  logic              cfg_yf;
  logic [SEED_W-1:0] cfg_seed;
  logic [2:0]        elem;
  logic [1:0]        step;

  // named internal events
  logic start_ok, step_last, elem_end, run_end, cur_desc, at_end, rd_issue, mismatch, fail_q;
  op_t  cur_op;
  logic [DATA_W-1:0] cur_word;

  assign start_ok  = start && (st == ST_IDLE || st == ST_DONE);
  assign cur_op    = op_at(cfg_alg, elem, step);
  assign cur_desc  = elem_desc(cfg_alg, elem);
  assign step_last = (step == final_step(cfg_alg, elem));
  assign elem_end  = (st == ST_RUN) && step_last && at_end;
  assign run_end   = elem_end && (elem == final_elem(cfg_alg));
  assign cur_word  = seed_word(cfg_seed, cur_op.inv);
  assign rd_issue  = mem_en && !cur_op.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cfg_alg  <= ALG_CP;
      cfg_yf   <= 1'b0;
      cfg_seed <= '0;
      elem     <= '0;
      step     <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: if (start_ok) begin
          cfg_alg  <= algo;
          cfg_yf   <= y_fast;
          cfg_seed <= seed;
          elem     <= '0;
          step     <= '0;
          st       <= ST_RUN;
        end
        ST_RUN: begin
          if (step_last) begin
            step <= '0;
            if (run_end)       st   <= ST_DRAIN;
            else if (at_end)   elem <= elem + 3'd1;
          end else begin
            step <= step + 2'd1;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  march_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok || (elem_end && !run_end)),
    .load_desc (start_ok ? 1'b0 : elem_desc(cfg_alg, elem + 3'd1)),
    .adv       ((st == ST_RUN) && step_last && !at_end),
    .desc      (cur_desc),
    .y_fast    (cfg_yf),
    .addr      (mem_addr),
    .at_end    (at_end)
  );

  march_cmp #(.AW(AW), .DW(DATA_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .rd_issue  (rd_issue),
    .exp_word  (cur_word),
    .rd_addr   (mem_addr),
    .rdata     (mem_rdata),
    .mismatch  (mismatch),
    .fail      (fail_q),
    .fail_addr (fail_addr)
  );

  assign mem_en    = (st == ST_RUN);
  assign mem_we    = mem_en && cur_op.wr;
  assign mem_wdata = cur_word;
  assign busy      = (st == ST_RUN) || (st == ST_DRAIN);
  assign done      = (st == ST_DONE);
  assign pass      = done && !fail_q;

endmodule

// File: rtl/march_engine_sva.sv
module march_engine_sva #(parameter int AW = 7) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [AW-1:0] fail_addr,
  input logic          elem_end,
  input logic          cur_desc,
  input logic          fail_q
);

  assert_start_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_en));

  assert_write_is_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && busy));

  assert_elem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    elem_end |-> (cur_desc ? (mem_addr == '0) : (mem_addr == '1)));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && busy) |=> fail_q);

  assert_first_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !start) |=> $stable(fail_addr));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(fail_addr)));

  assert_pass_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

endmodule

bind march_engine march_engine_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail_addr (fail_addr),
  .elem_end  (elem_end),
  .cur_desc  (cur_desc),
  .fail_q    (fail_q)
);

// File: tb/tb_march_engine.sv
module tb_march_engine;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int N  = 128;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start, y_fast;
  logic [1:0]    algo;
  logic [3:0]    seed;
  logic          mem_en, mem_we, busy, done, pass;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  march_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .algo(algo), .y_fast(y_fast), .seed(seed),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  // behavioural RAM with up to two stuck-at-1 locations
  logic [DW-1:0] ram [N];
  int flt_a = -1, flt_b = -1, flt_bit = 0;

  function automatic logic [DW-1:0] stuck(input logic [AW-1:0] a);
    if (int'(a) == flt_a || int'(a) == flt_b) return DW'(1) << flt_bit;
    return '0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr] | stuck(mem_addr);
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // element lists: leading 'd' marks descending, then op/value pairs
  function automatic string elem_str(input int a, input int e);
    string cp[6]  = '{"w0", "r0w1r1", "r1w0r0", "dr0w1r1", "dr1w0r0", "r0"};
    string rw[4]  = '{"w0", "r0w1", "dr1w0", "r0"};
    string rwr[4] = '{"w0", "r0w1r1", "dr1w0r0", "r0"};
    if (a == 1) return rw[e];
    if (a == 2) return rwr[e];
    return cp[e];
  endfunction

  function automatic int walk_addr(input bit yf, input int i);
    if (yf) return i;
    return (i % 16) * 8 + (i / 16);
  endfunction

  function automatic logic [DW-1:0] pat(input logic [3:0] s, input bit v);
    logic [DW-1:0] w;
    w = {4{s}};
    return v ? ~w : w;
  endfunction

  task automatic run(input int a, input bit yf, input logic [3:0] sd, input bit poke,
                     input bit exp_pass, input int exp_fa, input string req);
    int opn = 0, bad = 0;
    logic [31:0] b_act = 0, b_exp = 0;
    int nel;
    logic [AW-1:0] fa_hold;
    logic pass_hold;
    nel = (a == 1 || a == 2) ? 4 : 6;
    @(negedge clk); algo = 2'(a); y_fast = yf; seed = sd; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int e = 0; e < nel; e++) begin
      string s;
      bit d;
      int base, nops;
      s = elem_str(a, e);
      d = (s[0] == "d");
      base = d ? 1 : 0;
      nops = (s.len() - base) / 2;
      for (int k = 0; k < N; k++) begin
        int ad;
        ad = walk_addr(yf, d ? N - 1 - k : k);
        for (int o = 0; o < nops; o++) begin
          bit w, v;
          w = (s[base + 2*o] == "w");
          v = (s[base + 2*o + 1] == "1");
          if (opn > 0) @(negedge clk);
          if (poke && opn == 5) begin start = 1'b1; algo = 2'((a + 1) % 3); seed = ~sd; y_fast = ~yf; end
          if (poke && opn == 6) begin start = 1'b0; algo = 2'(a); seed = sd; y_fast = yf; end
          if (bad == 0 && !(mem_en && mem_we == w && int'(mem_addr) == ad &&
                            (!w || mem_wdata == pat(sd, v)))) begin
            bad = 1;
            b_act = {mem_en, mem_we, 7'(mem_addr), mem_wdata};
            b_exp = {1'b1, w, 7'(ad), pat(sd, v)};
            $display("  trace mismatch at element %0d op %0d", e, opn);
          end
          opn++;
        end
      end
    end
    chk(bad == 0, req, "command trace {en,we,addr,wdata}", b_act, b_exp);
    @(negedge clk);
    chk(busy && !done && !mem_en, "R10", "drain cycle {busy,done,en}",
        {busy, done, mem_en}, 3'b100);
    @(negedge clk);
    chk(done && !busy, "R10", "done rises {done,busy}", {done, busy}, 2'b10);
    chk(pass == exp_pass, "R9", "pass flag", pass, exp_pass);
    if (!exp_pass) chk(int'(fail_addr) == exp_fa, "R9", "first fail address", fail_addr, exp_fa);
    fa_hold = fail_addr; pass_hold = pass;
    repeat (4) @(negedge clk);
    chk(done && pass == pass_hold && fail_addr == fa_hold, "R10", "results held {done,pass,addr}",
        {done, pass, fail_addr}, {1'b1, pass_hold, fa_hold});
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; algo = 2'd0; y_fast = 1'b0; seed = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pass && !mem_en, "R11", "reset outputs {busy,done,pass,en}",
        {busy, done, pass, mem_en}, 4'b0000);
  endtask

  task automatic test_faults();
    flt_bit = 3; flt_a = 90; flt_b = 20;
    run(0, 1'b1, 4'h0, 1'b0, 1'b0, 20, "R9/R7 y-fast two faults");
    run(0, 1'b0, 4'h0, 1'b0, 1'b0, 90, "R9/R6 x-fast two faults");
    flt_bit = 0; flt_a = 77; flt_b = -1;
    run(1, 1'b1, 4'hF, 1'b0, 1'b0, 77, "R9/R8 inverse-word fault");
    flt_a = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    run(0, 1'b1, 4'h5, 1'b0, 1'b1, 0, "R2/R5/R7/R8 six-element y-fast");
    run(0, 1'b0, 4'hA, 1'b0, 1'b1, 0, "R2/R5/R6/R8 six-element x-fast");
    run(1, 1'b0, 4'h3, 1'b0, 1'b1, 0, "R3/R5/R6 read-write x-fast");
    run(2, 1'b1, 4'h6, 1'b1, 1'b1, 0, "R4/R1 read-write-read with start while busy");
    run(3, 1'b1, 4'hC, 1'b0, 1'b1, 0, "R2 spare code");
    test_faults();
    run(2, 1'b0, 4'h9, 1'b0, 1'b1, 0, "R1/R4 restart after fail clears result");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule